// File: doc/BRIEF.md
# Register-Mapped Serial Port Front End

This block places a byte-wide asynchronous serial port behind a simple 32-bit register bus with separate read and write strobes. Software sets the port up through a handful of registers: a control word with transmit and receive enables and two one-shot clear bits, a mode word, and two baud values. The two baud values are only stored here and are driven out to a separate baud generator. A status word shows whether the transmit queue is full and whether the receive queue is empty. A single data offset pushes bytes into the transmit queue on a write and pops bytes from the receive queue on a read.

Behind the registers there are two 16-entry byte queues and a pair of 8N1 line engines. Both engines are paced by `sample_tick`, a one-cycle strobe from the external baud generator that arrives OVS times per bit. The transmitter drains its queue only while it is enabled. The receiver finds a start edge, samples each bit in its middle, and stores the byte only when the stop bit is high and reception is enabled.

Top module: `uart_regif`

## Requirements
- R1: After reset, control, mode, both baud registers and the read data bus are all 0. The status word reads 0x02 (receive queue empty) and `txd` is high.
- R2: Control (offset 0x00) keeps 9 bits and mode (offset 0x04) keeps 11 bits. Higher bits read as 0. Control bits 1 and 0 always read back as 0.
- R3: The baud value at offset 0x18 keeps bits 15:0 and the divider at offset 0x34 keeps bits 7:0. Both appear on `baud_gen` and `baud_div` and read back through the bus.
- R4: Writing control with bit 1 set empties the transmit queue and stops the transmitter. Writing control with bit 0 set empties the receive queue and stops the receiver. Neither bit stays set.
- R5: Status (offset 0x2C) bit 4 reads 1 while the transmit queue holds 16 bytes. Bit 1 reads 1 while the receive queue is empty. All other status bits read 0.
- R6: A write to the data port (offset 0x30) while the transmit queue is full is discarded.
- R7: A read of the data port while the receive queue is empty returns 0 and leaves the queue unchanged.
- R8: With control bit 4 set and the transmit queue not empty, the transmitter sends each byte as a low start bit, 8 data bits LSB first, then a high stop bit. Each bit lasts OVS ticks.
- R9: While control bit 4 is clear, queued transmit bytes stay queued and `txd` stays high.
- R10: With control bit 2 set, each received frame with a high stop bit is appended to the receive queue. Data-port reads return the bytes in arrival order.
- R11: A frame with a low stop bit, a frame that arrives while control bit 2 is clear, and a frame that arrives while the receive queue holds 16 bytes are all dropped.
- R12: Read data is registered. It appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| sample_tick | input | 1 | Sample strobe, OVS pulses per bit |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| baud_gen | output | 16 | Stored baud generator value |
| baud_div | output | 8 | Stored baud divider value |

## Verification
The assertions assume that read and write strobes are never asserted in the same cycle. They also assume that `sample_tick` is a single-cycle pulse, and that a control write never sets a clear bit while a data-port access is in flight. The bench keeps within all three: every bus access is a single strobe from a task that runs one access at a time, and the tick comes from a free-running divide-by-four counter. Received frames are driven at exactly OVS ticks per bit, so the mid-bit sample always falls inside the intended bit.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_MODE = 'h04;
  localparam int unsigned OFS_BGEN = 'h18;
  localparam int unsigned OFS_STAT = 'h2C;
  localparam int unsigned OFS_DATA = 'h30;
  localparam int unsigned OFS_BDIV = 'h34;

  localparam int CB_TXEN  = 4;
  localparam int CB_RXEN  = 2;
  localparam int CB_TXCLR = 1;
  localparam int CB_RXCLR = 0;
  localparam int SB_TXFULL  = 4;
  localparam int SB_RXEMPTY = 1;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic       en,
  input  logic       q_empty,
  input  logic [7:0] din,
  output logic       pop,
  output logic       txd,
  output logic       busy
);
  localparam int CW = $clog2(OVS);

  logic [8:0]    sh;
  logic [3:0]    bitn;
  logic [CW-1:0] tcnt;

  assign pop = !busy && en && !q_empty && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      bitn <= '0;
      tcnt <= '0;
    end else if (pop) begin
      busy <= 1'b1;
      txd  <= 1'b0;
      sh   <= {1'b1, din};
      bitn <= '0;
      tcnt <= '0;
    end else if (busy && tick) begin
      if (tcnt == CW'(OVS-1)) begin
        tcnt <= '0;
        if (bitn == 4'd9) begin
          busy <= 1'b0;
        end else begin
          txd  <= sh[0];
          sh   <= {1'b1, sh[8:1]};
          bitn <= bitn + 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core import uart_regif_pkg::*; #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       tick,
  input  logic       en,
  input  logic       rxd_s,
  output logic       push,
  output logic [7:0] dout
);
  localparam int CW = $clog2(OVS);

  rx_state_t     st;
  logic [CW-1:0] tcnt;
  logic [2:0]    bitn;
  logic          last_tick;

  assign last_tick = (tcnt == CW'(OVS-1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st   <= RX_IDLE;
      tcnt <= '0;
      bitn <= '0;
      dout <= '0;
      push <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!rxd_s) begin
            st   <= RX_START;
            tcnt <= '0;
          end
          RX_START: begin
            if (tcnt == CW'(OVS/2-1)) begin
              tcnt <= '0;
              bitn <= '0;
              st   <= rxd_s ? RX_IDLE : RX_DATA;
            end else tcnt <= tcnt + 1'b1;
          end
          RX_DATA: begin
            if (last_tick) begin
              tcnt <= '0;
              dout <= {rxd_s, dout[7:1]};
              if (bitn == 3'd7) st <= RX_STOP;
              else bitn <= bitn + 1'b1;
            end else tcnt <= tcnt + 1'b1;
          end
          default: begin
            if (last_tick) begin
              tcnt <= '0;
              push <= rxd_s && en;
              st   <= RX_IDLE;
            end else tcnt <= tcnt + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif import uart_regif_pkg::*; #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sample_tick,
  input  logic              rxd,
  output logic              txd,
  output logic [15:0]       baud_gen,
  output logic [7:0]        baud_div
);
  localparam int CTRL_W = 9;
  localparam int MODE_W = 11;

  logic [CTRL_W-1:0] ctrl_q;
  logic [MODE_W-1:0] mode_q;
  logic [1:0]        rx_sync;
  logic unused_wdata;

  logic wr_ctrl, wr_data, rd_data;
  logic tx_clr, rx_clr;
  logic tx_pop, tx_full, tx_empty, tx_busy;
  logic rx_push, rx_full, rx_empty;
  logic [7:0] tx_dout, rx_byte, rx_dout;
  logic [DATA_W-1:0] stat_word;

  assign unused_wdata = ^bus_wdata[DATA_W-1:16];

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign rd_data = bus_rd && (bus_addr == ADDR_W'(OFS_DATA));
  assign tx_clr  = wr_ctrl && bus_wdata[CB_TXCLR];
  assign rx_clr  = wr_ctrl && bus_wdata[CB_RXCLR];

  always_comb begin
    stat_word = '0;
    stat_word[SB_TXFULL]  = tx_full;
    stat_word[SB_RXEMPTY] = rx_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) rx_sync <= 2'b11;
    else     rx_sync <= {rx_sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      baud_gen <= '0;
      baud_div <= '0;
    end else if (bus_wr) begin
      case (int'(bus_addr))
        OFS_CTRL: ctrl_q   <= {bus_wdata[CTRL_W-1:2], 2'b00};
        OFS_MODE: mode_q   <= bus_wdata[MODE_W-1:0];
        OFS_BGEN: baud_gen <= bus_wdata[15:0];
        OFS_BDIV: baud_div <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (int'(bus_addr))
        OFS_CTRL: bus_rdata <= DATA_W'(ctrl_q);
        OFS_MODE: bus_rdata <= DATA_W'(mode_q);
        OFS_BGEN: bus_rdata <= DATA_W'(baud_gen);
        OFS_STAT: bus_rdata <= stat_word;
        OFS_DATA: bus_rdata <= rx_empty ? '0 : DATA_W'(rx_dout);
        OFS_BDIV: bus_rdata <= DATA_W'(baud_div);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(wr_data), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout),
    .empty(tx_empty), .full(tx_full)
  );

  uart_tx_core #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .clr(tx_clr), .tick(sample_tick),
    .en(ctrl_q[CB_TXEN]), .q_empty(tx_empty), .din(tx_dout),
    .pop(tx_pop), .txd(txd), .busy(tx_busy)
  );

  byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_push), .din(rx_byte),
    .pop(rd_data), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full)
  );

  uart_rx_core #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .clr(rx_clr), .tick(sample_tick),
    .en(ctrl_q[CB_RXEN]), .rxd_s(rx_sync[1]),
    .push(rx_push), .dout(rx_byte)
  );
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk import uart_regif_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              txd,
  input logic              tx_busy,
  input logic              tx_pop,
  input logic              tx_full,
  input logic              tx_empty,
  input logic              rx_empty
);
  // R4
  tx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CB_TXCLR]) |=> tx_empty);

  // R4
  rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CB_RXCLR]) |=> rx_empty);

  // R7
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_DATA) && rx_empty) |=> (bus_rdata == '0 && rx_empty));

  // R6
  tx_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_DATA) && tx_full && !tx_pop) |=> tx_full);

  // R8
  tx_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> tx_busy);

  // R9
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd);

  // R2
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_CTRL)) |=> (bus_rdata[1:0] == 2'b00 && bus_rdata[DATA_W-1:9] == '0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .txd(txd), .tx_busy(tx_busy), .tx_pop(tx_pop), .tx_full(tx_full),
  .tx_empty(tx_empty), .rx_empty(rx_empty)
);

// File: tb/sim_uart_regif.sv
`timescale 1ns/1ps
module sim_uart_regif;
  localparam int BITCLK = 64;
  localparam int DEPTH  = 16;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic sample_tick = 0;
  logic rxd = 1;
  logic txd;
  logic [15:0] baud_gen;
  logic [7:0] baud_div;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [1:0] tdiv = 0;

  logic [15:0] m_bgen = 0;
  logic [7:0]  m_bdiv = 0;
  logic [8:0]  m_ctrl = 0;
  logic [10:0] m_mode = 0;
  byte unsigned exp_tx[$];
  byte unsigned exp_rx[$];
  int tx_seen = 0;

  uart_regif u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sample_tick(sample_tick), .rxd(rxd), .txd(txd),
    .baud_gen(baud_gen), .baud_div(baud_div)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 1'b1;
    sample_tick <= (tdiv == 2'd2);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  // per-clock comparison of the baud outputs and the idle line (R3, R9)
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (baud_gen !== m_bgen) check("R3 baud_gen", {16'h0, baud_gen}, {16'h0, m_bgen});
      if (baud_div !== m_bdiv) check("R3 baud_div", {24'h0, baud_div}, {24'h0, m_bdiv});
      if (!m_ctrl[4] && txd !== 1'b1) check("R9 txd idle", {31'h0, txd}, 32'h1);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    case (a)
      'h00: begin
        m_ctrl = {d[8:2], 2'b00};
        if (d[1]) exp_tx.delete();
        if (d[0]) exp_rx.delete();
      end
      'h04: m_mode = d[10:0];
      'h18: m_bgen = d[15:0];
      'h34: m_bdiv = d[7:0];
      'h30: if (exp_tx.size() < DEPTH) exp_tx.push_back(d[7:0]);
      default: ;
    endcase
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a); bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_stat();
    logic [31:0] s = 0;
    s[4] = (exp_tx.size() >= DEPTH);
    s[1] = (exp_rx.size() == 0);
    return s;
  endfunction

  task automatic chk_stat(input string req);
    logic [31:0] v;
    rd('h2C, v);
    check(req, v, exp_stat());
  endtask

  task automatic chk_rx_read(input string req);
    logic [31:0] v, e;
    e = (exp_rx.size() == 0) ? 32'h0 : {24'h0, exp_rx.pop_front()};
    rd('h30, v);
    check(req, v, e);
  endtask

  // drive one frame on rxd; the model stores it per R10/R11
  task automatic send_rx(input byte unsigned b, input bit good_stop);
    logic [9:0] f;
    f = {good_stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rxd = f[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd = 1;
    repeat (BITCLK) @(negedge clk);
    if (m_ctrl[2] && good_stop && exp_rx.size() < DEPTH) exp_rx.push_back(b);
  endtask

  // line monitor for R8: decode every frame at mid-bit and compare
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        logic [7:0] b;
        repeat (BITCLK/2) @(negedge clk);
        check("R8 start bit", {31'h0, txd}, 32'h0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITCLK) @(negedge clk);
          b[i] = txd;
        end
        repeat (BITCLK) @(negedge clk);
        check("R8 stop bit", {31'h0, txd}, 32'h1);
        tx_seen++;
        if (exp_tx.size() == 0) check("R8 unexpected frame", {24'h0, b}, 32'hFFFF_FFFF);
        else check("R8 tx byte", {24'h0, b}, {24'h0, exp_tx.pop_front()});
      end
    end
  end

  initial begin
    logic [31:0] v;
    int want;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 txd", {31'h0, txd}, 32'h1);
    check("R1 rdata", bus_rdata, 32'h0);
    rd('h00, v); check("R1 ctrl", v, 0);
    rd('h04, v); check("R1 mode", v, 0);
    rd('h18, v); check("R1 bgen", v, 0);
    rd('h34, v); check("R1 bdiv", v, 0);
    rd('h2C, v); check("R1 stat", v, 32'h2);

    // R2 register widths, self-clearing bits
    wr('h00, 32'hFFFF_FFFF); rd('h00, v); check("R2 ctrl", v, 32'h1FC);
    wr('h00, 32'h0);         rd('h00, v); check("R2 ctrl zero", v, 0);
    wr('h04, 32'hFFFF_FFFF); rd('h04, v); check("R2 mode", v, 32'h7FF);
    wr('h04, 32'h20);        rd('h04, v); check("R2 mode 8N1", v, 32'h20);

    // R3 baud registers
    wr('h18, 32'h1234_5678); rd('h18, v); check("R3 bgen", v, 32'h5678);
    wr('h34, 32'h0000_01AB); rd('h34, v); check("R3 bdiv", v, 32'hAB);

    // R12 read data holds between reads
    repeat (5) @(negedge clk);
    check("R12 hold", bus_rdata, 32'hAB);

    // R5, R6, R9: fill tx queue with transmitter off
    for (int i = 0; i < DEPTH + 1; i++) wr('h30, 32'h40 + i);
    chk_stat("R5 tx full");
    check("R6 queue depth", exp_tx.size(), DEPTH);
    repeat (200) @(negedge clk);
    check("R9 txd held", {31'h0, txd}, 32'h1);
    check("R9 no frames", tx_seen, 0);

    // R4 transmit clear
    wr('h00, 32'h2);
    rd('h00, v); check("R4 ctrl reads 0", v, 0);
    chk_stat("R4 tx cleared");

    // R8 transmit a few bytes
    wr('h30, 32'hA5); wr('h30, 32'h01); wr('h30, 32'h80); wr('h30, 32'hFF); wr('h30, 32'h3C);
    wr('h00, 32'h10);
    repeat (5 * 10 * BITCLK + 200) @(negedge clk);
    check("R8 frames sent", tx_seen, 5);
    wr('h00, 32'h0);

    // R8 full queue burst, dropping the 17th byte (R6)
    for (int i = 0; i < DEPTH + 1; i++) wr('h30, 32'h11 * i + 3);
    wr('h00, 32'h10);
    repeat (DEPTH * 10 * BITCLK + 200) @(negedge clk);
    check("R6 burst sent", tx_seen, 5 + DEPTH);
    check("R8 queue drained", exp_tx.size(), 0);
    wr('h00, 32'h0);

    // R7 empty read
    chk_rx_read("R7 empty read");
    chk_stat("R7 still empty");

    // R11 receiver disabled
    send_rx(8'h77, 1);
    chk_stat("R11 rx disabled");

    // R10 receive in order
    wr('h00, 32'h4);
    send_rx(8'h5A, 1); send_rx(8'h00, 1); send_rx(8'hC3, 1);
    chk_stat("R5 rx not empty");
    chk_rx_read("R10 byte0"); chk_rx_read("R10 byte1"); chk_rx_read("R10 byte2");
    chk_stat("R5 rx empty again");
    chk_rx_read("R7 read after drain");

    // R11 bad stop bit
    send_rx(8'h99, 0);
    chk_stat("R11 bad stop");
    send_rx(8'h66, 1);
    chk_rx_read("R11 next good frame");

    // R11 overflow on receive side
    for (int i = 0; i < DEPTH + 1; i++) send_rx(8'(8'h20 + i), 1);
    want = DEPTH;
    check("R11 model depth", exp_rx.size(), want);
    for (int i = 0; i < DEPTH; i++) chk_rx_read("R11 overflow order");
    chk_rx_read("R11 17th dropped");

    // R4 receive clear
    send_rx(8'h12, 1); send_rx(8'h34, 1);
    chk_stat("R4 rx before clear");
    wr('h00, 32'h5);
    rd('h00, v); check("R4 ctrl after rx clear", v, 32'h4);
    chk_stat("R4 rx cleared");
    chk_rx_read("R4 nothing left");

    finish_run();
  end
endmodule